// File: doc/BRIEF.md
# L1 Cache Line Flush Controller

This block keeps the per-line coherence state for a small write-through L1 data cache and carries out flush requests from the core. Each line is Invalid, Valid, Atomic-pending or Flushing. A flush to a line that is Invalid or Valid is accepted at once. The line then enters Flushing, and a single write-flush request goes to the L2. The request carries the line data, the accumulated byte write mask, the requester's sequence number, an issue timestamp and the index of the target L2 bank. The line stays in Flushing until a writeback acknowledge comes back. The controller then pulses a completion callback for the flushed address and invalidates the line.

Lines are direct-mapped by the index bits of the address. The line data is kept in a byte-enabled RAM with a registered read. A small line-event port stands in for the cache's fill and atomic paths, so that lines can become Valid, enter and leave Atomic-pending, and gather write-mask bits. A flush that cannot be served is held off with `flush_ready` low until the line can take it.

Top module: `l1_flush_ctrl`

## Requirements
- R1: Synchronous active-high reset leaves every line Invalid with an empty write mask and all outputs (`l2req_valid`, `done_valid`, `proto_err`) low.
- R2: With `flush_valid` high, `flush_ready` is high when the indexed line (address bits [OFF_BITS +: IDX_W]) is Invalid or Valid and no line event targets that index in the same cycle. In the cycle after acceptance, `l2req_valid` pulses once with the line-aligned address (low OFF_BITS bits zero) and the flush's sequence number, and the line enters Flushing.
- R3: Every write-flush request has `l2req_shared` and `l2req_slc` low, and `l2req_time` equals the number of clock cycles since reset was released, counted at the acceptance edge (first edge after reset counts as 0).
- R4: `l2req_bank` equals bits [BANK_LO +: BANK_BITS] of the flushed address.
- R5: While the indexed line is Atomic-pending, `flush_ready` stays low and no request is sent. Once the atomic completes, the held flush is accepted.
- R6: A flush to a line already in Flushing is stalled (`flush_ready` low) until the acknowledge for that line has returned.
- R7: A response of kind 1 (L2 writeback ack) or kind 2 (directory writeback ack) to a Flushing line pulses `done_valid` in the next cycle, with the stored aligned address and sequence number. The line becomes Invalid and its mask is cleared.
- R8: A writeback ack (kind 1 or 2) for a line not in Flushing pulses `proto_err` for one cycle and changes no state. Responses of kind 0 (data) or 3 are ignored.
- R9: A line event of kind 0 (fill) to an Invalid or Valid line writes the data bytes selected by its mask, ORs that mask into the line's write mask and makes the line Valid. A fill to an Atomic-pending or Flushing line has no effect. The request carries that mask and data.
- R10: A line event of kind 1 (atomic issue) moves an Invalid or Valid line to Atomic-pending. Kind 2 (atomic done) moves an Atomic-pending line to Valid and merges its data and mask like a fill. Otherwise both are ignored, as is kind 3.
- R11: A line event to the same index as a flush in the same cycle stalls the flush for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_valid | input | 1 | Core flush request present |
| flush_ready | output | 1 | Flush accepted this cycle when high |
| flush_addr | input | ADDR_W | Byte address to flush |
| flush_seq | input | SEQ_W | Requester sequence number |
| ev_valid | input | 1 | Line event present |
| ev_kind | input | 2 | 0 fill, 1 atomic issue, 2 atomic done, 3 none |
| ev_addr | input | ADDR_W | Event address (index bits used) |
| ev_data | input | DATA_W | Event data |
| ev_mask | input | DATA_W/8 | Event byte mask |
| l2req_valid | output | 1 | Write-flush request pulse to L2 |
| l2req_addr | output | ADDR_W | Line-aligned address |
| l2req_bank | output | BANK_BITS | Target L2 bank |
| l2req_data | output | DATA_W | Line data |
| l2req_mask | output | DATA_W/8 | Accumulated byte write mask |
| l2req_seq | output | SEQ_W | Sequence number |
| l2req_time | output | TIME_W | Issue timestamp |
| l2req_shared | output | 1 | Shared flag, always clear |
| l2req_slc | output | 1 | System-coherent flag, always clear |
| rsp_valid | input | 1 | Response from L2 present |
| rsp_kind | input | 2 | 0 data, 1 L2 writeback ack, 2 directory writeback ack |
| rsp_addr | input | ADDR_W | Response address (index bits used) |
| done_valid | output | 1 | Flush completion callback pulse |
| done_addr | output | ADDR_W | Completed line address |
| done_seq | output | SEQ_W | Completed sequence number |
| proto_err | output | 1 | Unexpected acknowledge pulse |

## Verification
A line left in the wrong state shows up at `flush_ready` in the very cycle a flush to that index is presented. It also shows up one cycle after the next acknowledge, as `done_valid` where `proto_err` was due or the reverse. A stale or uncleared write mask or data byte appears on the next write-flush request to that line. The bench's behavioural model tracks every line and compares ready on every cycle and all registered outputs one cycle after each edge, so any such fault is seen at its first visible cycle.

// File: rtl/flc_pkg.sv
package flc_pkg;
  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_VAL   = 2'd1,
    LS_ATOM  = 2'd2,
    LS_FLUSH = 2'd3
  } line_st_e;

  localparam logic [1:0] EK_FILL   = 2'd0;
  localparam logic [1:0] EK_AISSUE = 2'd1;
  localparam logic [1:0] EK_ADONE  = 2'd2;

  localparam logic [1:0] RK_DATA   = 2'd0;
  localparam logic [1:0] RK_L2ACK  = 2'd1;
  localparam logic [1:0] RK_DIRACK = 2'd2;
endpackage

// File: rtl/flc_data_ram.sv
module flc_data_ram #(
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [BYTES-1:0]  wbe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (we && wbe[b]) mem[waddr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flc_line_table.sv
module flc_line_table
  import flc_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int MASK_W = 4,
  parameter int ADDR_W = 16,
  parameter int SEQ_W  = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_go,
  input  logic [1:0]        ev_kind,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic [MASK_W-1:0] ev_mask,
  input  logic              acc_go,
  input  logic [IDX_W-1:0]  acc_idx,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SEQ_W-1:0]  acc_seq,
  input  logic              ack_go,
  input  logic [IDX_W-1:0]  ack_idx,
  output line_st_e          ev_st,
  output line_st_e          acc_st,
  output line_st_e          ack_st,
  output logic [MASK_W-1:0] acc_mask,
  output logic [ADDR_W-1:0] ack_addr,
  output logic [SEQ_W-1:0]  ack_seq
);
  line_st_e          st_q   [LINES];
  logic [MASK_W-1:0] mask_q [LINES];
  logic [ADDR_W-1:0] addr_q [LINES];
  logic [SEQ_W-1:0]  seq_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic ev_here, acc_here, ack_here, open_st;
    assign ev_here  = ev_go  && (ev_idx  == IDX_W'(g));
    assign acc_here = acc_go && (acc_idx == IDX_W'(g));
    assign ack_here = ack_go && (ack_idx == IDX_W'(g));
    assign open_st  = (st_q[g] == LS_INV) || (st_q[g] == LS_VAL);

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g]   <= LS_INV;
        mask_q[g] <= '0;
      end else if (acc_here) begin
        st_q[g]   <= LS_FLUSH;
        addr_q[g] <= acc_addr;
        seq_q[g]  <= acc_seq;
      end else if (ack_here && st_q[g] == LS_FLUSH) begin
        st_q[g]   <= LS_INV;
        mask_q[g] <= '0;
      end else if (ev_here) begin
        unique case (ev_kind)
          EK_FILL: if (open_st) begin
            st_q[g]   <= LS_VAL;
            mask_q[g] <= mask_q[g] | ev_mask;
          end
          EK_AISSUE: if (open_st) st_q[g] <= LS_ATOM;
          EK_ADONE: if (st_q[g] == LS_ATOM) begin
            st_q[g]   <= LS_VAL;
            mask_q[g] <= mask_q[g] | ev_mask;
          end
          default: ;
        endcase
      end
    end
  end

  assign ev_st    = st_q[ev_idx];
  assign acc_st   = st_q[acc_idx];
  assign ack_st   = st_q[ack_idx];
  assign acc_mask = mask_q[acc_idx];
  assign ack_addr = addr_q[ack_idx];
  assign ack_seq  = seq_q[ack_idx];
endmodule

// File: rtl/flc_out_regs.sv
module flc_out_regs #(
  parameter int ADDR_W    = 16,
  parameter int MASK_W    = 4,
  parameter int SEQ_W     = 8,
  parameter int TIME_W    = 16,
  parameter int BANK_LO   = 5,
  parameter int BANK_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_go,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [SEQ_W-1:0]     acc_seq,
  input  logic [MASK_W-1:0]    acc_mask,
  input  logic                 ack_ok,
  input  logic                 ack_bad,
  input  logic [ADDR_W-1:0]    ack_addr,
  input  logic [SEQ_W-1:0]     ack_seq,
  output logic                 req_valid,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [BANK_BITS-1:0] req_bank,
  output logic [MASK_W-1:0]    req_mask,
  output logic [SEQ_W-1:0]     req_seq,
  output logic [TIME_W-1:0]    req_time,
  output logic                 done_valid,
  output logic [ADDR_W-1:0]    done_addr,
  output logic [SEQ_W-1:0]     done_seq,
  output logic                 err
);
  logic [TIME_W-1:0] now_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q      <= '0;
      req_valid  <= 1'b0;
      done_valid <= 1'b0;
      err        <= 1'b0;
    end else begin
      now_q      <= now_q + 1'b1;
      req_valid  <= acc_go;
      done_valid <= ack_ok;
      err        <= ack_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (acc_go) begin
      req_addr <= acc_addr;
      req_bank <= acc_addr[BANK_LO +: BANK_BITS];
      req_mask <= acc_mask;
      req_seq  <= acc_seq;
      req_time <= now_q;
    end
    if (ack_ok) begin
      done_addr <= ack_addr;
      done_seq  <= ack_seq;
    end
  end
endmodule

// File: rtl/l1_flush_ctrl.sv
module l1_flush_ctrl
  import flc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int SEQ_W     = 8,
  parameter int TIME_W    = 16,
  parameter int LINES     = 8,
  parameter int OFF_BITS  = 2,
  parameter int BANK_LO   = 5,
  parameter int BANK_BITS = 2,
  localparam int MASK_W   = DATA_W / 8,
  localparam int IDX_W    = $clog2(LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush_valid,
  output logic                 flush_ready,
  input  logic [ADDR_W-1:0]    flush_addr,
  input  logic [SEQ_W-1:0]     flush_seq,
  input  logic                 ev_valid,
  input  logic [1:0]           ev_kind,
  input  logic [ADDR_W-1:0]    ev_addr,
  input  logic [DATA_W-1:0]    ev_data,
  input  logic [MASK_W-1:0]    ev_mask,
  output logic                 l2req_valid,
  output logic [ADDR_W-1:0]    l2req_addr,
  output logic [BANK_BITS-1:0] l2req_bank,
  output logic [DATA_W-1:0]    l2req_data,
  output logic [MASK_W-1:0]    l2req_mask,
  output logic [SEQ_W-1:0]     l2req_seq,
  output logic [TIME_W-1:0]    l2req_time,
  output logic                 l2req_shared,
  output logic                 l2req_slc,
  input  logic                 rsp_valid,
  input  logic [1:0]           rsp_kind,
  input  logic [ADDR_W-1:0]    rsp_addr,
  output logic                 done_valid,
  output logic [ADDR_W-1:0]    done_addr,
  output logic [SEQ_W-1:0]     done_seq,
  output logic                 proto_err
);
  logic [IDX_W-1:0]  fl_idx, ev_idx, rsp_idx;
  logic [ADDR_W-1:0] fl_aligned, tbl_ack_addr;
  logic [SEQ_W-1:0]  tbl_ack_seq;
  logic [MASK_W-1:0] tbl_acc_mask;
  line_st_e          ev_st, acc_st, ack_st;
  logic              acc_go, ack_go, ram_we, ev_clash;
  logic              unused_bits;

  assign fl_idx     = flush_addr[OFF_BITS +: IDX_W];
  assign ev_idx     = ev_addr[OFF_BITS +: IDX_W];
  assign rsp_idx    = rsp_addr[OFF_BITS +: IDX_W];
  assign fl_aligned = {flush_addr[ADDR_W-1:OFF_BITS], {OFF_BITS{1'b0}}};
  assign unused_bits = ^{ev_addr, rsp_addr};

  assign ev_clash    = ev_valid && (ev_idx == fl_idx);
  assign flush_ready = ((acc_st == LS_INV) || (acc_st == LS_VAL)) && !ev_clash;
  assign acc_go      = flush_valid && flush_ready;
  assign ack_go      = rsp_valid && ((rsp_kind == RK_L2ACK) || (rsp_kind == RK_DIRACK));
  assign ram_we      = ev_valid &&
                       (((ev_kind == EK_FILL) && ((ev_st == LS_INV) || (ev_st == LS_VAL))) ||
                        ((ev_kind == EK_ADONE) && (ev_st == LS_ATOM)));

  flc_line_table #(
    .LINES(LINES), .MASK_W(MASK_W), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W)
  ) u_tbl (
    .clk(clk), .rst(rst),
    .ev_go(ev_valid), .ev_kind(ev_kind), .ev_idx(ev_idx), .ev_mask(ev_mask),
    .acc_go(acc_go), .acc_idx(fl_idx), .acc_addr(fl_aligned), .acc_seq(flush_seq),
    .ack_go(ack_go), .ack_idx(rsp_idx),
    .ev_st(ev_st), .acc_st(acc_st), .ack_st(ack_st),
    .acc_mask(tbl_acc_mask), .ack_addr(tbl_ack_addr), .ack_seq(tbl_ack_seq)
  );

  flc_data_ram #(.LINES(LINES), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ev_idx), .wbe(ev_mask), .wdata(ev_data),
    .raddr(fl_idx), .rdata(l2req_data)
  );

  flc_out_regs #(
    .ADDR_W(ADDR_W), .MASK_W(MASK_W), .SEQ_W(SEQ_W), .TIME_W(TIME_W),
    .BANK_LO(BANK_LO), .BANK_BITS(BANK_BITS)
  ) u_out (
    .clk(clk), .rst(rst),
    .acc_go(acc_go), .acc_addr(fl_aligned), .acc_seq(flush_seq), .acc_mask(tbl_acc_mask),
    .ack_ok(ack_go && (ack_st == LS_FLUSH)), .ack_bad(ack_go && (ack_st != LS_FLUSH)),
    .ack_addr(tbl_ack_addr), .ack_seq(tbl_ack_seq),
    .req_valid(l2req_valid), .req_addr(l2req_addr), .req_bank(l2req_bank),
    .req_mask(l2req_mask), .req_seq(l2req_seq), .req_time(l2req_time),
    .done_valid(done_valid), .done_addr(done_addr), .done_seq(done_seq), .err(proto_err)
  );

  assign l2req_shared = 1'b0;
  assign l2req_slc    = 1'b0;
endmodule

// File: rtl/flc_chk.sv
module flc_chk #(
  parameter int ADDR_W    = 16,
  parameter int SEQ_W     = 8,
  parameter int BANK_LO   = 5,
  parameter int BANK_BITS = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 flush_valid,
  input logic                 flush_ready,
  input logic [ADDR_W-1:0]    flush_addr,
  input logic [SEQ_W-1:0]     flush_seq,
  input logic                 l2req_valid,
  input logic [BANK_BITS-1:0] l2req_bank,
  input logic [SEQ_W-1:0]     l2req_seq,
  input logic                 rsp_valid,
  input logic [1:0]           rsp_kind,
  input logic                 done_valid,
  input logic                 proto_err
);
  // R2
  req_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_valid && flush_ready) |=> (l2req_valid && l2req_seq == $past(flush_seq)));

  // R2
  req_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    l2req_valid |-> $past(flush_valid && flush_ready));

  // R4
  bank_bits_chk: assert property (@(posedge clk) disable iff (rst)
    l2req_valid |-> (l2req_bank == $past(flush_addr[BANK_LO +: BANK_BITS])));

  // R7
  done_has_ack_chk: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> ($past(rsp_valid) && ($past(rsp_kind) == 2'd1 || $past(rsp_kind) == 2'd2)));

  // R8
  err_has_ack_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> ($past(rsp_valid) && ($past(rsp_kind) == 2'd1 || $past(rsp_kind) == 2'd2)));

  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_valid && proto_err));
endmodule

bind l1_flush_ctrl flc_chk #(
  .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .BANK_LO(BANK_LO), .BANK_BITS(BANK_BITS)
) u_chk (
  .clk(clk), .rst(rst), .flush_valid(flush_valid), .flush_ready(flush_ready),
  .flush_addr(flush_addr), .flush_seq(flush_seq), .l2req_valid(l2req_valid),
  .l2req_bank(l2req_bank), .l2req_seq(l2req_seq), .rsp_valid(rsp_valid),
  .rsp_kind(rsp_kind), .done_valid(done_valid), .proto_err(proto_err)
);

// File: tb/sim_l1_flush_ctrl.sv
module sim_l1_flush_ctrl;
  localparam int PERIOD = 10;
  localparam int AW = 16, DW = 32, SW = 8, TW = 16, NL = 8, OB = 2, BL = 5, BB = 2;
  localparam int MW = DW / 8;

  logic clk = 1'b0, rst;
  logic flush_valid, flush_ready; logic [AW-1:0] flush_addr; logic [SW-1:0] flush_seq;
  logic ev_valid; logic [1:0] ev_kind; logic [AW-1:0] ev_addr; logic [DW-1:0] ev_data; logic [MW-1:0] ev_mask;
  logic l2req_valid; logic [AW-1:0] l2req_addr; logic [BB-1:0] l2req_bank; logic [DW-1:0] l2req_data;
  logic [MW-1:0] l2req_mask; logic [SW-1:0] l2req_seq; logic [TW-1:0] l2req_time; logic l2req_shared, l2req_slc;
  logic rsp_valid; logic [1:0] rsp_kind; logic [AW-1:0] rsp_addr;
  logic done_valid; logic [AW-1:0] done_addr; logic [SW-1:0] done_seq; logic proto_err;

  always #(PERIOD/2) clk = ~clk;

  l1_flush_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SEQ_W(SW), .TIME_W(TW), .LINES(NL),
                  .OFF_BITS(OB), .BANK_LO(BL), .BANK_BITS(BB)) u0 (.*);

  int checks = 0, fails = 0;
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // behavioural reference model: state 0 inv, 1 valid, 2 atomic, 3 flushing
  int mst [NL]; logic [MW-1:0] mmask [NL]; logic [DW-1:0] mdata [NL]; logic [MW-1:0] mknown [NL];
  logic [AW-1:0] maddr [NL]; logic [SW-1:0] mseq [NL];
  int mcyc; bit started = 0;
  bit e_rv, e_dv, e_err; logic [AW-1:0] e_raddr, e_daddr; logic [SW-1:0] e_rseq, e_dseq;
  logic [MW-1:0] e_rmask, e_rknown; logic [DW-1:0] e_rdata; int e_rtime;

  function automatic int ix(logic [AW-1:0] a); return int'(a[OB +: 3]); endfunction

  function automatic bit m_ready();
    int fi = ix(flush_addr);
    return (mst[fi] <= 1) && !(ev_valid && ix(ev_addr) == fi);
  endfunction

  always @(posedge clk) begin
    started = 1;
    e_rv = 0; e_dv = 0; e_err = 0;
    if (rst) begin
      mcyc = 0;
      for (int i = 0; i < NL; i++) begin mst[i] = 0; mmask[i] = '0; end
    end else begin
      automatic int fi = ix(flush_addr), ei = ix(ev_addr), ri = ix(rsp_addr);
      automatic int ev_pre = mst[ei];
      automatic bit acc = flush_valid && m_ready();
      if (acc) begin
        e_rv = 1; e_raddr = {flush_addr[AW-1:OB], 2'b00}; e_rseq = flush_seq;
        e_rmask = mmask[fi]; e_rdata = mdata[fi]; e_rknown = mknown[fi]; e_rtime = mcyc;
      end
      if (rsp_valid && (rsp_kind == 2'd1 || rsp_kind == 2'd2)) begin
        if (mst[ri] == 3) begin
          e_dv = 1; e_daddr = maddr[ri]; e_dseq = mseq[ri]; mst[ri] = 0; mmask[ri] = '0;
        end else e_err = 1;
      end
      if (ev_valid) begin
        if ((ev_kind == 2'd0 && ev_pre <= 1) || (ev_kind == 2'd2 && ev_pre == 2)) begin
          mst[ei] = 1; mmask[ei] = mmask[ei] | ev_mask;
          for (int b = 0; b < MW; b++)
            if (ev_mask[b]) begin mdata[ei][b*8 +: 8] = ev_data[b*8 +: 8]; mknown[ei][b] = 1'b1; end
        end else if (ev_kind == 2'd1 && ev_pre <= 1) mst[ei] = 2;
      end
      if (acc) begin mst[fi] = 3; maddr[fi] = e_raddr; mseq[fi] = flush_seq; end
      mcyc++;
    end
  end

  // registered outputs, one half period after each edge
  always @(negedge clk) if (started) begin
    chk("R2 req_valid", l2req_valid, e_rv);
    if (e_rv && l2req_valid) begin
      chk("R2 req_addr", l2req_addr, e_raddr);
      chk("R2 req_seq", l2req_seq, e_rseq);
      chk("R9 req_mask", l2req_mask, e_rmask);
      for (int b = 0; b < MW; b++)
        if (e_rknown[b]) chk("R9 req_data", l2req_data[b*8 +: 8], e_rdata[b*8 +: 8]);
      chk("R4 req_bank", l2req_bank, e_raddr[BL +: BB]);
      chk("R3 req_time", l2req_time, e_rtime[TW-1:0]);
      chk("R3 req_flags", {l2req_shared, l2req_slc}, 2'b00);
    end
    chk("R7 done_valid", done_valid, e_dv);
    if (e_dv && done_valid) begin
      chk("R7 done_addr", done_addr, e_daddr);
      chk("R7 done_seq", done_seq, e_dseq);
    end
    chk("R8 proto_err", proto_err, e_err);
  end

  // combinational ready, after the new inputs settle
  always @(negedge clk) if (started && !rst) begin
    #2;
    if (flush_valid) begin
      automatic int fi = ix(flush_addr);
      if (ev_valid && ix(ev_addr) == fi) chk("R11 ready", flush_ready, m_ready());
      else if (mst[fi] == 2) chk("R5 R10 ready", flush_ready, m_ready());
      else if (mst[fi] == 3) chk("R6 ready", flush_ready, m_ready());
      else chk("R2 ready", flush_ready, m_ready());
    end
  end

  task automatic tick(); @(negedge clk); #1; endtask
  task automatic idle();
    flush_valid = 0; flush_addr = '0; flush_seq = '0;
    ev_valid = 0; ev_kind = 2'd3; ev_addr = '0; ev_data = '0; ev_mask = '0;
    rsp_valid = 0; rsp_kind = 2'd0; rsp_addr = '0;
  endtask
  task automatic do_ev(logic [1:0] k, logic [AW-1:0] a, logic [DW-1:0] d, logic [MW-1:0] m);
    ev_valid = 1; ev_kind = k; ev_addr = a; ev_data = d; ev_mask = m; tick(); ev_valid = 0;
  endtask
  task automatic do_rsp(logic [1:0] k, logic [AW-1:0] a);
    rsp_valid = 1; rsp_kind = k; rsp_addr = a; tick(); rsp_valid = 0;
  endtask
  task automatic do_flush(logic [AW-1:0] a, logic [SW-1:0] s, int n);
    flush_valid = 1; flush_addr = a; flush_seq = s;
    for (int i = 0; i < n; i++) tick();
    flush_valid = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; idle();
    repeat (3) tick();
    // R1 reset state
    chk("R1 req_valid", l2req_valid, 0);
    chk("R1 done_valid", done_valid, 0);
    chk("R1 proto_err", proto_err, 0);
    rst = 0; tick();
    // R9 fill then flush from Valid, L2 ack (R7)
    do_ev(2'd0, 16'h0024, 32'hA1B2C3D4, 4'hF);
    do_ev(2'd0, 16'h0024, 32'h00EE0000, 4'h4);
    do_flush(16'h0025, 8'h11, 1); tick();
    do_rsp(2'd1, 16'h0024); tick();
    // flush from Invalid (R1 empty mask), directory ack
    do_flush(16'h0048, 8'h22, 1); tick();
    do_rsp(2'd2, 16'h0048); tick();
    // R8 ack on an Invalid line, data response ignored
    do_rsp(2'd1, 16'h0048); tick();
    do_rsp(2'd0, 16'h0024); do_rsp(2'd3, 16'h0024); tick();
    // R10 atomic then R5 stall, R11 clash with atomic done
    do_ev(2'd0, 16'h006C, 32'h11223344, 4'h3);
    do_ev(2'd1, 16'h006C, 32'h0, 4'h0);
    do_flush(16'h006C, 8'h33, 3);
    flush_valid = 1; ev_valid = 1; ev_kind = 2'd2; ev_addr = 16'h006C; ev_data = 32'h55000000; ev_mask = 4'h8;
    tick(); ev_valid = 0; tick(); flush_valid = 0;
    // R6 second flush while Flushing; R9 fill ignored while Flushing
    do_flush(16'h006C, 8'h34, 2);
    do_ev(2'd0, 16'h006C, 32'hFFFFFFFF, 4'hF);
    do_rsp(2'd2, 16'h006C); tick();
    do_flush(16'h006C, 8'h35, 1); tick(); do_rsp(2'd1, 16'h006C); tick();
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      flush_valid = ($urandom % 2) == 0; flush_addr = AW'($urandom); flush_seq = SW'($urandom);
      ev_valid = ($urandom % 3) == 0; ev_kind = 2'($urandom); ev_addr = AW'($urandom);
      ev_data = $urandom; ev_mask = MW'($urandom);
      rsp_valid = ($urandom % 3) == 0; rsp_kind = 2'($urandom); rsp_addr = AW'($urandom);
      tick();
    end
    idle(); repeat (4) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule